// File: doc/BRIEF.md
# Three-Stage Bubble-Carrying Transform Pipeline

This block takes 16-bit words from the head of an upstream FIFO and applies three fixed transforms to each one: add a step, shift left, XOR with a mask. It writes each result into a downstream FIFO. Two tagged slot registers separate the three transforms. Every slot register advances on every clock edge, whether or not a word is waiting upstream. A cycle with nothing to take leaves an invalid bubble in the first slot, and that bubble moves forward like data. A word therefore never waits for a later word to push it out.

Upstream, the block looks at a not-empty flag and the head word. It raises its dequeue strobe in the same cycle in which it captures the head. Downstream, it raises an enqueue strobe with the result only when the last slot holds a valid word. The downstream FIFO is taken to be deep enough never to be full when it is written.

Top module: `tagpipe3`

## Requirements
- R1: While reset is low, both slot tags are cleared. With no upstream data, `dst_push` stays 0 through the first cycles after reset is released.
- R2: Outside reset, `src_pop` equals `src_nonempty` in every cycle. The head word is captured at the same clock edge at which it is dequeued. During reset `src_pop` is 0.
- R3: A clock edge at which `src_nonempty` is 0 loads a bubble. Two edges later, no enqueue occurs for that slot.
- R4: A word dequeued at clock edge k is presented with `dst_push` = 1 during the cycle that follows edge k+1. The downstream FIFO takes it at edge k+2, so the latency is exactly two cycles.
- R5: For a head word h, `dst_data` = (((h + 1) mod 2^16) << 1, truncated to 16 bits) XOR 16'hA5A5. Bits shifted out at the top are lost, so 16'hFFFF yields 16'hA5A5 and 16'h8000 yields 16'hA5A7.
- R6: Every dequeued word produces exactly one enqueue. Words leave in the order in which they were dequeued.
- R7: The pipeline never stalls. N words that are available on consecutive edges produce N enqueues on N consecutive cycles.
- R8: The downstream FIFO is never full when `dst_push` is 1. This holds for the environment the bench builds: a downstream FIFO of depth 8 that may pause draining during a burst of at most 6 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_nonempty | input | 1 | Upstream FIFO holds at least one word |
| src_head | input | 16 | Word at the head of the upstream FIFO |
| src_pop | output | 1 | Dequeue strobe to the upstream FIFO |
| dst_push | output | 1 | Enqueue strobe to the downstream FIFO |
| dst_data | output | 16 | Word to enqueue downstream |

## Verification
The bench sends a lone word, which shows the two-cycle latency with nothing around it. It then sends a six-word burst while the downstream FIFO stops draining, which shows the pipeline advancing one word per cycle without stalling. Alternating single-word gaps and irregular gaps of zero to two idle cycles check that bubbles keep data apart, produce no enqueues of their own, and leave the order unchanged. The words 0xFFFF, 0x7FFF, 0x8000 and 0x0000 check the carry out of the adder and the bit lost from the top by the shifter.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Selects which fixed transform a stage instance computes.
    typedef enum logic [1:0] {
        XF_ADD = 2'd0,
        XF_SHL = 2'd1,
        XF_XOR = 2'd2
    } xf_kind_e;

endpackage

// File: rtl/tp_xform.sv
module tp_xform #(
    parameter int                 DATA_W = 16,
    parameter tp_pkg::xf_kind_e   KIND   = tp_pkg::XF_ADD,
    parameter logic [DATA_W-1:0]  ARG    = '0
) (
    input  logic [DATA_W-1:0] x,
    output logic [DATA_W-1:0] y
);

    // One combinational transform; the parameter picks which one is built.
    generate
        if (KIND == tp_pkg::XF_ADD) begin : g_add
            assign y = x + ARG;
        end else if (KIND == tp_pkg::XF_SHL) begin : g_shl
            assign y = x << ARG;
        end else begin : g_xor
            assign y = x ^ ARG;
        end
    endgenerate

endmodule

// File: rtl/tp_slot.sv
module tp_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_dat
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } slot_t;

    slot_t st_d, st_q;

    // The tag follows the input on every edge. The payload is held
    // while a bubble passes, so idle cycles do not toggle the data bits.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.dat = in_dat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_dat = st_q.dat;

endmodule

// File: rtl/tagpipe3.sv
module tagpipe3 #(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] STEP   = 16'h0001,
    parameter logic [DATA_W-1:0] SHAMT  = 16'h0001,
    parameter logic [DATA_W-1:0] MASK   = 16'hA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_nonempty,
    input  logic [DATA_W-1:0] src_head,
    output logic              src_pop,
    output logic              dst_push,
    output logic [DATA_W-1:0] dst_data
);

    logic [DATA_W-1:0] xf1_y, xf2_y, xf3_y;
    logic              s1_vld, s2_vld;
    logic [DATA_W-1:0] s1_dat, s2_dat;
    logic              take;

    // Front: the head is taken whenever one is present and the block is out of reset.
    assign take    = src_nonempty & rst_n;
    assign src_pop = take;

    tp_xform #(.DATA_W(DATA_W), .KIND(tp_pkg::XF_ADD), .ARG(STEP)) u_xf1 (
        .x (src_head),
        .y (xf1_y)
    );

    tp_slot #(.DATA_W(DATA_W)) u_slot1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (src_nonempty),
        .in_dat  (xf1_y),
        .out_vld (s1_vld),
        .out_dat (s1_dat)
    );

    tp_xform #(.DATA_W(DATA_W), .KIND(tp_pkg::XF_SHL), .ARG(SHAMT)) u_xf2 (
        .x (s1_dat),
        .y (xf2_y)
    );

    tp_slot #(.DATA_W(DATA_W)) u_slot2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s1_vld),
        .in_dat  (xf2_y),
        .out_vld (s2_vld),
        .out_dat (s2_dat)
    );

    tp_xform #(.DATA_W(DATA_W), .KIND(tp_pkg::XF_XOR), .ARG(MASK)) u_xf3 (
        .x (s2_dat),
        .y (xf3_y)
    );

    // Back: write only for a valid slot; a bubble leaves the strobe low.
    assign dst_push = s2_vld;
    assign dst_data = xf3_y;

endmodule

// File: rtl/tagpipe3_chk.sv
module tagpipe3_chk #(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] STEP   = 16'h0001,
    parameter logic [DATA_W-1:0] SHAMT  = 16'h0001,
    parameter logic [DATA_W-1:0] MASK   = 16'hA5A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_nonempty,
    input logic [DATA_W-1:0] src_head,
    input logic              src_pop,
    input logic              dst_push,
    input logic [DATA_W-1:0] dst_data
);

    function automatic logic [DATA_W-1:0] ref_xf(input logic [DATA_W-1:0] h);
        logic [DATA_W-1:0] t;
        t = h + STEP;
        t = t << SHAMT;
        return t ^ MASK;
    endfunction

    // R1: the first edge out of reset sees cleared tags.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dst_push);

    // R3: an empty upstream cycle produces no write two edges later.
    assert_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_nonempty |=> ##1 !dst_push);

    // R4: a dequeue is followed by a write after exactly two edges.
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |=> ##1 dst_push);

    // R5: the written word is the composed transform of the dequeued head.
    assert_transform_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |=> ##1 (dst_data == ref_xf($past(src_head, 2))));

endmodule

bind tagpipe3 tagpipe3_chk #(
    .DATA_W (DATA_W),
    .STEP   (STEP),
    .SHAMT  (SHAMT),
    .MASK   (MASK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_nonempty (src_nonempty),
    .src_head     (src_head),
    .src_pop      (src_pop),
    .dst_push     (dst_push),
    .dst_data     (dst_data)
);

// File: tb/sim_tagpipe3.sv
`timescale 1ns/1ps
module sim_tagpipe3;

    localparam int DW        = 16;
    localparam int DST_DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_nonempty = 1'b0;
    logic [DW-1:0] src_head = '0;
    logic          src_pop, dst_push;
    logic [DW-1:0] dst_data;

    always #2 clk = ~clk;   // 250 MHz

    tagpipe3 u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_nonempty (src_nonempty),
        .src_head     (src_head),
        .src_pop      (src_pop),
        .dst_push     (dst_push),
        .dst_data     (dst_data)
    );

    logic [DW-1:0] src_q[$];
    logic [DW-1:0] exp_q[$];
    int            exp_cyc_q[$];
    int            cyc = 0;
    int            occ = 0;
    bit            drain_en = 1'b1;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] model(input logic [DW-1:0] v);
        logic [DW-1:0] t;
        t = v + 16'd1;
        t = t << 1;
        return t ^ 16'hA5A5;
    endfunction

    task automatic refresh();
        src_nonempty = (src_q.size() > 0);
        src_head     = (src_q.size() > 0) ? src_q[0] : '0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: loads the upstream FIFO and records the expected result.
    task automatic put(input logic [DW-1:0] v);
        src_q.push_back(v);
        exp_q.push_back(model(v));
        refresh();
    endtask

    task automatic slot_in();
        @(negedge clk);
        #1;
    endtask

    // Monitor: compares writes against the scoreboard and models both FIFOs.
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1 push in reset", {31'd0, dst_push}, 32'd0);
            check("R2 pop in reset", {31'd0, src_pop}, 32'd0);
        end else begin
            if (dst_push) begin
                check("R8 downstream not full", {31'd0, (occ >= DST_DEPTH)}, 32'd0);
                occ++;
                if (exp_q.size() == 0) begin
                    check("R6 unexpected write", 32'd1, 32'd0);
                end else begin
                    check("R5/R6 data", {16'd0, dst_data}, {16'd0, exp_q.pop_front()});
                    check("R4 write cycle", cyc, exp_cyc_q.pop_front());
                end
            end else if (exp_cyc_q.size() > 0 && exp_cyc_q[0] == cyc) begin
                check("R4 missing write", 32'd0, 32'd1);
                void'(exp_cyc_q.pop_front());
                void'(exp_q.pop_front());
            end else begin
                check("R3 bubble gives no write", {31'd0, dst_push}, 32'd0);
            end
            check("R2 pop equals nonempty", {31'd0, src_pop}, {31'd0, src_nonempty});
            if (src_pop) begin
                void'(src_q.pop_front());
                exp_cyc_q.push_back(cyc + 1);
                refresh();
            end
            if (drain_en && occ > 0) occ--;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: idle cycles after reset release give no write.
        repeat (3) begin
            @(negedge clk);
            #1 check("R1 no write after reset", {31'd0, dst_push}, 32'd0);
        end

        // Lone word.
        slot_in(); put(16'h1234);
        repeat (5) @(negedge clk);

        // R7: six words back to back with draining paused.
        slot_in();
        drain_en = 1'b0;
        for (int i = 0; i < 6; i++) put(16'h0100 + 16'(i));
        repeat (7) @(negedge clk);
        #1 check("R7 six writes in six cycles", occ, 6);
        drain_en = 1'b1;
        repeat (8) @(negedge clk);

        // Alternating gaps.
        for (int i = 0; i < 5; i++) begin
            slot_in(); put(16'hA000 + 16'(i));
            @(negedge clk);
        end
        repeat (4) @(negedge clk);

        // R5 corner words: adder carry and shift loss.
        slot_in();
        put(16'hFFFF); put(16'h7FFF); put(16'h8000); put(16'h0000);
        repeat (6) @(negedge clk);

        // Irregular gaps.
        for (int i = 0; i < 8; i++) begin
            slot_in(); put(16'(i) * 16'h1111);
            repeat (i % 3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        #1;
        check("R6 all words delivered", exp_q.size(), 0);
        check("R2 upstream drained", src_q.size(), 0);
        check("R5 0xFFFF maps to A5A5", {16'd0, model(16'hFFFF)}, 32'h0000A5A5);
        finish_run();
    end

endmodule